// File: doc/BRIEF.md
# Display Line Latch and Drive-Level Selector

This block stores one display line of per-channel on/off bits and turns each stored bit into a choice of one drive level out of four for every output channel. A line-load strobe is sampled in the system clock domain. When the block sees that strobe fall, it copies the parallel load word into its line store. The store keeps that line until the next falling edge of the strobe.

Each channel produces a one-hot 4-bit level-select code. Bit 0 selects V1, bit 1 selects V2, bit 2 selects V3 and bit 3 selects V4. V1 and V2 are selection (on) levels and V3 and V4 are non-selection (off) levels. A stored 1 means the channel is selected. Which level is used depends on the stored bit, the frame-alternation input and the mode input. The column mapping and the common mapping differ. An active-low blanking input forces every channel to V1 and leaves the stored line untouched.

Top module: `lcd_line_level_sel`

## Requirements
- R1: A synchronous active-low reset clears every stored bit to 0. After release, with blanking inactive, every channel selects a non-selection level.
- R2: The line store changes only on a cycle in which `line_clk` is sampled low after being sampled high on the previous cycle. Changes of `load_data`, and rising edges of `line_clk`, do not alter the outputs.
- R3: On a detected falling edge of `line_clk`, the store takes the `load_data` value present on that edge's clock cycle. Bit i goes to channel i, and the new value drives the outputs from the next cycle.
- R4: Each channel's 4-bit select code always has exactly one bit set.
- R5: Column mode (`col_mode`=1), blanking inactive. The codes are: frame_alt=0 and bit=1 gives V1 (0001); frame_alt=0 and bit=0 gives V3 (0100); frame_alt=1 and bit=1 gives V2 (0010); frame_alt=1 and bit=0 gives V4 (1000).
- R6: Common mode (`col_mode`=0), blanking inactive. The codes are: frame_alt=0 and bit=1 gives V2 (0010); frame_alt=0 and bit=0 gives V3 (0100); frame_alt=1 and bit=1 gives V1 (0001); frame_alt=1 and bit=0 gives V4 (1000).
- R7: While `blank_n` is 0, every channel outputs V1 (0001), whatever the mode, frame_alt or stored data.
- R8: Blanking does not alter the stored line. When `blank_n` returns to 1, the outputs again reflect the line stored before blanking, together with any line loaded during blanking.
- R9: The mode, frame_alt and blanking inputs act on the outputs in the same cycle, with no register between them and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Line-load strobe; the store loads on its falling edge |
| load_data | input | CH | Parallel line data from the load register, bit i for channel i |
| frame_alt | input | 1 | Frame-alternation polarity |
| col_mode | input | 1 | 1 = column mapping, 0 = common mapping |
| blank_n | input | 1 | Active-low display blanking |
| lvl_sel | output | 4*CH | One-hot level select per channel, channel i at [4i+3:4i] |

## Verification
On every cycle the assertions check the following. Each code is one-hot. Blanking yields V1 everywhere. Each mode keeps every channel within the two levels its frame_alt phase allows. The outputs hold still when no strobe fall occurs and the controls are steady. A load places exactly the sampled bits on the selection levels. Only the bench's scenarios can show that the stored line survives blanking and reappears intact. The same holds for the exact level chosen for each bit: the assertions accept either level of a phase, while the bench's cycle model pins down which one. Single-channel loads at both ends of the word, all-ones and all-zeros lines, and the sweep of mode and frame_alt over the same stored line also come from the bench.

// File: rtl/lcd_line_level_sel.sv
module lcd_line_level_sel #(
  parameter int CH = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_clk,
  input  logic [CH-1:0]   load_data,
  input  logic            frame_alt,
  input  logic            col_mode,
  input  logic            blank_n,
  output logic [4*CH-1:0] lvl_sel
);
  localparam int SELW = 4;

  logic          strobe_q;
  logic          strobe_fall;
  logic [CH-1:0] line_q;

  assign strobe_fall = strobe_q & ~line_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      line_q   <= '0;
    end else begin
      strobe_q <= line_clk;
      if (strobe_fall) line_q <= load_data;
    end
  end

  // on-level index: column uses V1/V2 by frame_alt, common swaps them
  logic on_hi;
  assign on_hi = frame_alt ^ ~col_mode;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [SELW-1:0] code;
    always_comb begin
      if (!blank_n)       code = 4'b0001;
      else if (line_q[i]) code = on_hi ? 4'b0010 : 4'b0001;
      else                code = frame_alt ? 4'b1000 : 4'b0100;
    end
    assign lvl_sel[SELW*i +: SELW] = code;
  end
endmodule

// File: rtl/lcd_line_level_sel_chk.sv
module lcd_line_level_sel_chk #(
  parameter int CH = 80
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_clk,
  input logic [CH-1:0]   load_data,
  input logic            frame_alt,
  input logic            col_mode,
  input logic            blank_n,
  input logic [4*CH-1:0] lvl_sel
);
  logic lc_prev;
  logic seen_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc_prev  <= 1'b0;
      seen_rst <= 1'b1;
    end else begin
      lc_prev  <= line_clk;
    end
  end

  a_r2_hold_without_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clk || !lc_prev) ##1 ($stable(frame_alt) && $stable(col_mode) && $stable(blank_n))
    |-> $stable(lvl_sel));

  a_r7_blank_all_v1: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (lvl_sel == {CH{4'b0001}}));

  for (genvar i = 0; i < CH; i++) begin : g_a
    logic [3:0] c;
    assign c = lvl_sel[4*i +: 4];

    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(c) == 1);

    a_r5_column_levels: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && col_mode) |-> (frame_alt ? (c == 4'b0010 || c == 4'b1000)
                                           : (c == 4'b0001 || c == 4'b0100)));

    a_r6_common_levels: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && !col_mode) |-> (frame_alt ? (c == 4'b0001 || c == 4'b1000)
                                            : (c == 4'b0010 || c == 4'b0100)));

    a_r3_load_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_prev && !line_clk) ##1 blank_n |-> ((c[0] | c[1]) == $past(load_data[i])));

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_rst && $past(!rst_n) && blank_n) |-> (c[2] | c[3]));
  end
endmodule

bind lcd_line_level_sel lcd_line_level_sel_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .load_data(load_data),
  .frame_alt(frame_alt), .col_mode(col_mode), .blank_n(blank_n), .lvl_sel(lvl_sel)
);

// File: tb/lcd_line_level_sel_bench.sv
module lcd_line_level_sel_bench;
  localparam int CH = 80;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            line_clk = 1'b0;
  logic [CH-1:0]   load_data = '0;
  logic            frame_alt = 1'b0;
  logic            col_mode = 1'b1;
  logic            blank_n = 1'b1;
  logic [4*CH-1:0] lvl_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [CH-1:0] ref_line = '0;
  bit            ref_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_line_level_sel #(.CH(CH)) u_lcd_line_level_sel (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .load_data(load_data),
    .frame_alt(frame_alt), .col_mode(col_mode), .blank_n(blank_n), .lvl_sel(lvl_sel)
  );

  function automatic logic [3:0] exp_code(bit d, bit m, bit col, bit bl);
    if (!bl) return 4'b0001;
    if (!d)  return m ? 4'b1000 : 4'b0100;
    if (col) return m ? 4'b0010 : 4'b0001;
    return m ? 4'b0001 : 4'b0010;
  endfunction

  function automatic logic [4*CH-1:0] exp_all();
    logic [4*CH-1:0] v;
    for (int i = 0; i < CH; i++) v[4*i +: 4] = exp_code(ref_line[i], frame_alt, col_mode, blank_n);
    return v;
  endfunction

  task automatic check(string req, logic [4*CH-1:0] expv);
    n_run++;
    if (lvl_sel !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, lvl_sel, expv);
    end
  endtask

  // one clock: model updates at the edge, compare at the following falling clock edge
  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      ref_line = '0;
      ref_prev = 0;
    end else begin
      if (ref_prev && !line_clk) ref_line = load_data;
      ref_prev = line_clk;
    end
    @(negedge clk);
    if (rst_n) check(!blank_n ? "R7 cycle" : (col_mode ? "R5 cycle" : "R6 cycle"), exp_all());
  endtask

  task automatic load_line(logic [CH-1:0] d);
    line_clk = 1'b1; tick();
    load_data = d; line_clk = 1'b0; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0] pat_a, pat_b;
    pat_a = '0;
    for (int i = 0; i < CH; i += 2) pat_a[i] = 1'b1;
    pat_b = ~pat_a;

    load_data = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset clear", {CH{4'b0100}});

    // R3: alternating load
    load_line(pat_a);
    check("R3 load pat_a", exp_all());

    // R2: data churn with strobe steady low, then a rising edge
    load_data = pat_b; tick(); tick();
    check("R2 no fall no load", exp_all());
    line_clk = 1'b1; tick();
    check("R2 rising edge no load", exp_all());
    line_clk = 1'b0; tick();
    check("R3 fall loads pat_b", exp_all());

    // R5/R6/R9: sweep polarity and mode on the stored line
    for (int k = 0; k < 4; k++) begin
      col_mode = k[1]; frame_alt = k[0];
      #1;
      check("R9 same-cycle control", exp_all());
      tick();
      check(col_mode ? "R5 column map" : "R6 common map", exp_all());
    end

    // boundary single-channel lines
    col_mode = 1'b1; frame_alt = 1'b0;
    load_line({{(CH-1){1'b0}}, 1'b1});
    check("R3 channel 0", {{(CH-1){4'b0100}}, 4'b0001});
    load_line({1'b1, {(CH-1){1'b0}}});
    check("R3 last channel", {4'b0001, {(CH-1){4'b0100}}});
    col_mode = 1'b0; frame_alt = 1'b1;
    load_line('1);
    check("R6 all ones", {CH{4'b0001}});
    load_line('0);
    check("R6 all zeros", {CH{4'b1000}});

    // R7/R8: blank, then restore
    load_line(pat_a);
    blank_n = 1'b0; tick();
    check("R7 blank all V1", {CH{4'b0001}});
    frame_alt = 1'b0; col_mode = 1'b1; tick();
    check("R7 blank any mode", {CH{4'b0001}});
    blank_n = 1'b1; tick();
    check("R8 restore retained line", exp_all());
    blank_n = 1'b0;
    load_line(pat_b);
    blank_n = 1'b1; tick();
    check("R8 load during blank", exp_all());

    // R4: every code one-hot on the final state
    begin
      bit ok = 1;
      for (int i = 0; i < CH; i++) if ($countones(lvl_sel[4*i +: 4]) != 1) ok = 0;
      n_run++;
      if (!ok) begin n_fail++; $display("FAIL R4 onehot: got %h expected one-hot codes", lvl_sel); end
    end

    // R1 again: mid-run reset
    rst_n = 1'b0; tick(); rst_n = 1'b1; frame_alt = 1'b0; col_mode = 1'b1; tick();
    check("R1 reset mid-run", {CH{4'b0100}});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule